// File: doc/BRIEF.md
# Addressed Serial DAC Register Loader

This block takes write frames from a three-wire serial link and loads them into a bank of channel code registers. The link has an active-low frame sync, a serial clock and a data line. Each frame carries a channel address and a converter code. All three serial lines are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The serial clock must therefore run at least four times slower than the system clock.

The bit count alone decides how long a frame lasts. The first sync falling edge seen while the loader is idle arms a frame and clears the counter. The frame then ends on its nineteenth sampled bit. Sync edges that arrive while a frame is armed have no effect. Serial clocks that arrive while the loader is idle also have no effect. When the nineteenth bit lands, the addressed register takes the new code. In that same cycle a one-cycle strobe reports the channel and the code, so downstream logic can follow each update. All channel values are also available at once on a flat output bus.

Top module: `serial_dac_loader`

## Requirements
- R1: A frame holds 19 bits, sent most significant bit first. The first 5 bits are the channel address (bit 18 down to bit 14 of the frame word). The last 14 bits are the code (bit 13 down to bit 0). The written code equals those 14 bits in straight binary.
- R2: The data line is sampled on each falling edge of the serial clock, after both lines pass through the synchronizers.
- R3: While the loader is idle, serial clock falling edges are ignored. The loader is idle before any sync falling edge, and again after the nineteenth bit until the next sync falling edge.
- R4: A sync falling edge while the loader is idle arms a new frame and restarts the bit count from zero.
- R5: While a frame is armed, sync edges in either direction are ignored. The frame completes on its nineteenth bit whatever the sync level. The bits sampled before and after such edges form one frame.
- R6: After the nineteenth bit, the addressed register holds the new code. In that same cycle, `updStb` is high for exactly one cycle, with `updChan` and `updCode` carrying the address and the code.
- R7: No other channel register changes. A frame that has fewer than 19 bits sampled writes nothing and raises no strobe.
- R8: With `rstN` low, all channel registers read zero, the strobe is low and the loader is idle. This holds from an asynchronous assertion of reset, including one in the middle of a frame.
- R9: Frames load correctly with a free-running serial clock and with a serial clock that has idle gaps between bits.
- R10: Every one of the 32 addresses selects its own register, and codes from 0 to 16383 are stored exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Serial frame sync, active low, asynchronous to clk |
| sclkIn | input | 1 | Serial clock, asynchronous to clk |
| sdIn | input | 1 | Serial data, sampled on the serial clock's falling edge |
| chanCodes | output | 448 | All channel codes, channel n at bits [14n+13:14n] |
| updStb | output | 1 | One-cycle strobe for each completed write |
| updChan | output | 5 | Channel written, valid while updStb is high |
| updCode | output | 14 | Code written, valid while updStb is high |

## Verification
The assertions check the following on every cycle:
- While the strobe is high, the reported channel's register equals the reported code.
- The register bank never changes without a strobe.
- The strobe never lasts two cycles.
- The loader is disarmed in the cycle of the strobe.
- No strobe follows an idle cycle.
- The outputs are clear during reset.

Only the bench scenarios can show the following:
- The bit order and the address decode across all 32 channels.
- That sync pulses inside a frame and trailing clocks are ignored.
- That a partial frame joins with the bits that follow it.
- Behaviour under gapped serial clocks.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  // Strobes passed from the control to the datapath each system cycle.
  typedef struct packed {
    logic shiftEn;  // sample one serial bit into the shift register
    logic commit;   // this bit is the last of the frame: write the bank
  } loadCtrl_t;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/dacld_ctrl.sv
module dacld_ctrl
  import dacld_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CODE_W = 14,
  localparam int FRAME_BITS = ADDR_W + CODE_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameS,
  input  logic             sclkS,
  output loadCtrl_t        ctrl,
  output logic             armed,
  output logic [CNT_W-1:0] bitCnt
);
  logic prevFrame, prevSclk;
  logic frameFall, sclkFall;

  assign frameFall = prevFrame & ~frameS;
  assign sclkFall  = prevSclk & ~sclkS;

  always_comb begin
    ctrl.shiftEn = armed & sclkFall;
    ctrl.commit  = armed & sclkFall & (bitCnt == CNT_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFrame <= 1'b1;
      prevSclk  <= 1'b0;
      armed     <= 1'b0;
      bitCnt    <= '0;
    end else begin
      prevFrame <= frameS;
      prevSclk  <= sclkS;
      if (armed) begin
        // sync edges are not looked at while a frame is open
        if (ctrl.commit) begin
          armed  <= 1'b0;
          bitCnt <= '0;
        end else if (ctrl.shiftEn) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (frameFall) begin
        armed  <= 1'b1;
        bitCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/dacld_datapath.sv
module dacld_datapath
  import dacld_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CODE_W = 14,
  localparam int FRAME_BITS = ADDR_W + CODE_W,
  localparam int NCH = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  loadCtrl_t             ctrl,
  input  logic                  dataS,
  output logic [NCH*CODE_W-1:0] chanCodes,
  output logic                  updStb,
  output logic [ADDR_W-1:0]     updChan,
  output logic [CODE_W-1:0]     updCode
);
  logic [FRAME_BITS-2:0] shiftReg;
  logic [FRAME_BITS-1:0] newWord;
  logic [ADDR_W-1:0]     wrAddr;
  logic [CODE_W-1:0]     wrCode;

  assign newWord = {shiftReg, dataS};
  assign wrAddr  = newWord[FRAME_BITS-1 -: ADDR_W];
  assign wrCode  = newWord[CODE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctrl.shiftEn) shiftReg <= newWord[FRAME_BITS-2:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : gBank
    logic [CODE_W-1:0] codeReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) codeReg <= '0;
      else if (ctrl.commit && wrAddr == ADDR_W'(g)) codeReg <= wrCode;
    end
    assign chanCodes[g*CODE_W +: CODE_W] = codeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updStb  <= 1'b0;
      updChan <= '0;
      updCode <= '0;
    end else begin
      updStb <= ctrl.commit;
      if (ctrl.commit) begin
        updChan <= wrAddr;
        updCode <= wrCode;
      end
    end
  end
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
  import dacld_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CODE_W = 14,
  parameter int SYNC_STAGES = 2,
  localparam int NCH = 1 << ADDR_W,
  localparam int FRAME_BITS = ADDR_W + CODE_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameN,
  input  logic                  sclkIn,
  input  logic                  sdIn,
  output logic [NCH*CODE_W-1:0] chanCodes,
  output logic                  updStb,
  output logic [ADDR_W-1:0]     updChan,
  output logic [CODE_W-1:0]     updCode
);
  logic [2:0]       syncVec;
  loadCtrl_t        ctrlS;
  logic             armedW;
  logic [CNT_W-1:0] bitCntW;

  // order: {frame, sclk, data}; frame idles high
  dacld_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({frameN, sclkIn, sdIn}),
    .syncOut(syncVec)
  );

  dacld_ctrl #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .frameS(syncVec[2]), .sclkS(syncVec[1]),
    .ctrl(ctrlS), .armed(armedW), .bitCnt(bitCntW)
  );

  dacld_datapath #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrlS), .dataS(syncVec[0]),
    .chanCodes(chanCodes), .updStb(updStb),
    .updChan(updChan), .updCode(updCode)
  );
endmodule

// File: rtl/dacld_chk.sv
module dacld_chk #(
  parameter int ADDR_W = 5,
  parameter int CODE_W = 14,
  localparam int NCH = 1 << ADDR_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NCH*CODE_W-1:0] chanCodes,
  input logic                  updStb,
  input logic [ADDR_W-1:0]     updChan,
  input logic [CODE_W-1:0]     updCode,
  input logic                  armed
);
  // R6: the strobed channel already holds the strobed code
  a_r6_strobe_matches_bank: assert property (@(posedge clk) disable iff (!rstN)
    updStb |-> (chanCodes[updChan*CODE_W +: CODE_W] == updCode));

  // R6: the strobe lasts a single cycle
  a_r6_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    updStb |=> !updStb);

  // R7: the bank only moves together with a strobe
  a_r7_bank_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !updStb |-> $stable(chanCodes));

  // R3: an idle loader cannot produce a write in the next cycle
  a_r3_no_write_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !updStb);

  // R4: the frame closes on its last bit
  a_r4_disarmed_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    updStb |-> !armed);

  // R8: reset clears the outputs
  always @(posedge clk) begin
    if (!rstN) begin
      a_r8_reset_clear: assert (chanCodes == '0 && !updStb && !armed);
    end
  end
endmodule

bind serial_dac_loader dacld_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .chanCodes(chanCodes), .updStb(updStb),
  .updChan(updChan), .updCode(updCode), .armed(armedW)
);

// File: tb/sim_serial_dac_loader.sv
module sim_serial_dac_loader;
  localparam int AW = 5;
  localparam int CW = 14;
  localparam int NCH = 1 << AW;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic sclkIn = 1'b1;
  logic sdIn = 1'b0;
  logic [NCH*CW-1:0] chanCodes;
  logic updStb;
  logic [AW-1:0] updChan;
  logic [CW-1:0] updCode;

  always #10 clk = ~clk;

  serial_dac_loader u0 (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclkIn(sclkIn), .sdIn(sdIn),
    .chanCodes(chanCodes), .updStb(updStb), .updChan(updChan), .updCode(updCode)
  );

  int total = 0;
  int bad = 0;
  int stbCnt = 0;
  logic [AW-1:0] lastChan;
  logic [CW-1:0] lastCode;
  logic [CW-1:0] model [NCH];

  always @(negedge clk) begin
    if (updStb) begin
      stbCnt++;
      lastChan = updChan;
      lastCode = updCode;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkBank(input string tag);
    int mis = -1;
    for (int c = 0; c < NCH; c++)
      if (mis < 0 && int'(chanCodes[c*CW +: CW]) != int'(model[c])) mis = c;
    total++;
    if (mis >= 0) begin
      bad++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, mis,
               chanCodes[mis*CW +: CW], model[mis]);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits of w starting at MSB-relative index startIdx
  task automatic sendBits(input logic [18:0] w, input int startIdx, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      sdIn = w[18 - startIdx - i];
      waitClk(HALF);
      sclkIn = 1'b0;
      waitClk(HALF);
      sclkIn = 1'b1;
      waitClk(gap);
    end
  endtask

  task automatic writeFrame(input int ch, input int code, input int gap);
    logic [18:0] w;
    w = {AW'(ch), CW'(code)};
    frameN = 1'b0;
    waitClk(HALF);
    sendBits(w, 0, 19, gap);
    frameN = 1'b1;
    waitClk(10);
    model[ch] = CW'(code);
  endtask

  task automatic checkStrobe(input string tag, input int expCnt, input int ch, input int code);
    checkEq({tag, " strobe count"}, stbCnt, expCnt);
    checkEq({tag, " chan"}, int'(lastChan), ch);
    checkEq({tag, " code"}, int'(lastCode), code);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    waitClk(3);
    checkEq("R8 reset bank zero", int'(chanCodes == '0), 1);
    checkEq("R8 reset strobe low", int'(updStb), 0);
    rstN = 1'b1;
    waitClk(5);

    // R10 R1 R2 R6 R7: every channel, arithmetic codes
    for (int c = 0; c < NCH; c++) begin
      int code = (c * 515 + 7 * c * c) & 16'h3FFF;
      if (c == 0) code = 16383;
      if (c == 31) code = 1;
      writeFrame(c, code, 0);
      checkStrobe("R10 R1 R6 sweep", c + 1, c, code);
      checkBank("R7 R10 bank after sweep write");
    end

    // R9: gapped serial clock, several gap lengths
    for (int g = 1; g <= 4; g++) begin
      int ch = g * 7;
      int code = 16383 - g * 1111;
      writeFrame(ch, code, g * 5);
      checkStrobe("R9 gapped clock", NCH + g, ch, code);
      checkBank("R9 bank after gapped write");
    end

    // R10: code zero
    writeFrame(5, 0, 0);
    checkStrobe("R10 zero code", NCH + 5, 5, 0);

    // R3: serial clocks with sync high do nothing
    sendBits(19'h7FFFF, 0, 19, 0);
    waitClk(10);
    checkEq("R3 idle clocks no strobe", stbCnt, NCH + 5);
    checkBank("R3 idle clocks bank");

    // R3: trailing clocks after the 19th bit with sync still low
    begin
      logic [18:0] w;
      w = {5'd9, 14'd4242};
      frameN = 1'b0;
      waitClk(HALF);
      sendBits(w, 0, 19, 0);
      sendBits({5'd9, 14'd77}, 0, 19, 0);
      frameN = 1'b1;
      waitClk(10);
      model[9] = 14'd4242;
      checkStrobe("R3 trailing clocks", NCH + 6, 9, 4242);
      checkBank("R3 trailing clocks bank");
    end

    // R5: sync pulse inside a frame is ignored
    begin
      logic [18:0] w;
      w = {5'd17, 14'd12345};
      frameN = 1'b0;
      waitClk(HALF);
      sendBits(w, 0, 8, 0);
      frameN = 1'b1;
      waitClk(6);
      frameN = 1'b0;
      waitClk(6);
      sendBits(w, 8, 11, 0);
      frameN = 1'b1;
      waitClk(10);
      model[17] = 14'd12345;
      checkStrobe("R5 mid-frame sync pulse", NCH + 7, 17, 12345);
      checkBank("R5 bank after glitch frame");
    end

    // R7: partial frame writes nothing; R5: its bits join the next ones
    begin
      logic [18:0] wa, wb, comb;
      wa = {5'd22, 14'd1000};
      wb = {5'd3, 14'd9999};
      comb = {wa[18:9], wb[8:0]};
      frameN = 1'b0;
      waitClk(HALF);
      sendBits(wa, 0, 10, 0);
      frameN = 1'b1;
      waitClk(30);
      checkEq("R7 partial frame no strobe", stbCnt, NCH + 7);
      checkBank("R7 partial frame bank");
      frameN = 1'b0;
      waitClk(HALF);
      sendBits(wb, 10, 9, 0);
      frameN = 1'b1;
      waitClk(10);
      model[comb[18:14]] = comb[13:0];
      checkStrobe("R5 joined frame", NCH + 8, int'(comb[18:14]), int'(comb[13:0]));
      checkBank("R5 joined frame bank");
    end

    // R8: reset in mid-frame, then R4: a fresh frame arms from zero
    frameN = 1'b0;
    waitClk(HALF);
    sendBits({5'd30, 14'd555}, 0, 7, 0);
    rstN = 1'b0;
    waitClk(2);
    for (int c = 0; c < NCH; c++) model[c] = '0;
    checkBank("R8 mid-frame reset clears bank");
    checkEq("R8 strobe low in reset", int'(updStb), 0);
    frameN = 1'b1;
    rstN = 1'b1;
    waitClk(5);
    writeFrame(30, 8191, 0);
    checkStrobe("R4 fresh frame after reset", NCH + 9, 30, 8191);
    checkBank("R4 bank after fresh frame");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule